// File: doc/BRIEF.md
# IDE Channel Mode Address Decoder

This block holds the configuration registers of a two-channel IDE controller and turns IO addresses into register-block hits. Each channel runs either in legacy compatibility mode, where it answers at fixed IO addresses, or in native mode, where software places its command and control windows with base registers. A per-channel native bit in the programming-interface byte selects the mode. The same bit shows or hides that channel's base registers, decides whether the interrupt-line byte is writable, and sends the channel's interrupt to either its legacy IRQ pin or its own native IRQ pin.

The configuration port takes a dword index, four byte enables and write data. A write strobe is accepted on every clock edge and is never stalled, so the port has no ready signal and no back-pressure. Read data is combinational on the dword index. The IO side is also combinational: a strobe plus an address gives at most one of four hit outputs in the same cycle.

Top module: `ide_mode_decoder`

## Requirements
- R1: After reset, dword index 02h (byte offset 08h) reads 0101_8A01h. Bits 31:16 are always 0101h, bits 7:0 are always the revision parameter, and in the programming-interface byte (bits 15:8) bits 9, 11 and 15 always read 1 and bits 14:12 always read 0.
- R2: Dword bit 8 is the primary native select and bit 10 is the secondary native select. Both reset to 0 and are written only when byte enable 1 is set. No other bit of dword 02h is changed by a write.
- R3: In compatibility mode the primary channel gives a command hit for IO 1F0h–1F7h and a control hit only for 3F6h. The secondary channel does the same for 170h–177h and 376h.
- R4: In native mode a channel gives a command hit when IO address bits 31:3 equal bits 31:3 of its command base. It gives a control hit only when address bits 31:2 equal bits 31:2 of its control base and address bits 1:0 are 10b.
- R5: Base registers are at dword indices 04h/05h (primary command/control) and 06h/07h (secondary). While their channel is in compatibility mode they read 0 and ignore writes. In native mode they read the stored base with bit 0 = 1, and the other reserved low bits (2:1 for command, 1 for control) read 0.
- R6: The base registers reset to 0000_01F1h, 0000_03F5h, 0000_0171h and 0000_0375h. These values are seen once the channel enters native mode.
- R7: Dword index 0Fh holds the interrupt-line byte (bits 7:0) and the interrupt-pin byte (bits 15:8). When neither channel is native, the line reads 0 and ignores writes and the pin reads 00h. When either channel is native, the line is read-write and the pin reads 01h. Bits 31:16 read 0.
- R8: A channel's interrupt request drives its legacy IRQ output in compatibility mode and its native IRQ output in native mode, never both.
- R9: Dword index 03h bits 15:8 form a read-write latency byte that affects nothing else. Its other bytes read 0.
- R10: A write changes only the bytes whose enables are set.
- R11: No hit is asserted without the IO strobe, and at most one hit is asserted at a time. When windows overlap, the priority is primary command, then primary control, then secondary command, then secondary control.
- R12: All other dword indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| io_strobe | input | 1 | IO access qualifier |
| io_addr | input | 32 | IO address |
| pri_cmd_hit | output | 1 | Primary command block hit |
| pri_ctl_hit | output | 1 | Primary control block hit |
| sec_cmd_hit | output | 1 | Secondary command block hit |
| sec_ctl_hit | output | 1 | Secondary control block hit |
| pri_irq_req | input | 1 | Primary channel interrupt request |
| sec_irq_req | input | 1 | Secondary channel interrupt request |
| pri_legacy_irq | output | 1 | Primary legacy IRQ line |
| sec_legacy_irq | output | 1 | Secondary legacy IRQ line |
| pri_native_irq | output | 1 | Primary native-mode IRQ line |
| sec_native_irq | output | 1 | Secondary native-mode IRQ line |

## Verification
A wrong native bit shows up in the same cycle on every face of its channel: the decode windows move, the base registers read back as zero or non-zero, the pin byte changes, and the interrupt goes to the other pin. A base register that has been corrupted or written by mistake becomes visible in the first readback or IO access after the channel enters native mode. That is why the random mix keeps switching modes and probes addresses both next to the live windows and next to the stale ones. Decode and read paths are combinational, so every mismatch appears one cycle after the write that caused it.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  // configuration dword indices
  localparam int IDX_ID   = 'h02;
  localparam int IDX_MISC = 'h03;
  localparam int IDX_PCMD = 'h04;
  localparam int IDX_INTR = 'h0F;
  localparam int NUM_BASE = 4;

  localparam logic [31:0] CMD_WMASK = 32'hFFFF_FFF8;
  localparam logic [31:0] CTL_WMASK = 32'hFFFF_FFFC;
  localparam logic [31:0] IO_SPACE_FLAG = 32'h0000_0001;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
#(
  parameter int          CFG_AW   = 6,
  parameter logic [7:0]  REVISION = 8'h01,
  parameter logic [31:0] PRI_CMD_LEG = 32'h1F0,
  parameter logic [31:0] PRI_CTL_LEG = 32'h3F6,
  parameter logic [31:0] SEC_CMD_LEG = 32'h170,
  parameter logic [31:0] SEC_CTL_LEG = 32'h376
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic [1:0]             native,
  output logic [NUM_BASE-1:0][31:0] base_val
);
  localparam logic [NUM_BASE-1:0][31:0] LEG = {SEC_CTL_LEG, SEC_CMD_LEG, PRI_CTL_LEG, PRI_CMD_LEG};

  logic [1:0] pi_q;
  logic [7:0] lat_q;
  logic [7:0] line_q;
  logic       any_native;

  assign native     = pi_q;
  assign any_native = |pi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pi_q   <= '0;
      lat_q  <= '0;
      line_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == CFG_AW'(IDX_ID) && cfg_be[1])
        pi_q <= {cfg_wdata[10], cfg_wdata[8]};
      if (cfg_addr == CFG_AW'(IDX_MISC) && cfg_be[1])
        lat_q <= cfg_wdata[15:8];
      if (cfg_addr == CFG_AW'(IDX_INTR) && cfg_be[0] && any_native)
        line_q <= cfg_wdata[7:0];
    end
  end

  // even index: command base, odd index: control base; index/2 = channel
  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    localparam logic [31:0] WM  = (g % 2 == 1) ? CTL_WMASK : CMD_WMASK;
    localparam logic [31:0] RST = LEG[g] & WM;
    logic [31:0] q;
    logic        wr_sel;
    logic [31:0] m;
    assign wr_sel = cfg_wr && (cfg_addr == CFG_AW'(IDX_PCMD + g)) && native[g/2];
    assign m      = WM & be_mask(cfg_be);
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= RST;
      else if (wr_sel) q <= (q & ~m) | (cfg_wdata & m);
    end
    assign base_val[g] = q;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(IDX_ID))
      cfg_rdata = {16'h0101, 1'b1, 3'b000, 1'b1, pi_q[1], 1'b1, pi_q[0], REVISION};
    else if (cfg_addr == CFG_AW'(IDX_MISC))
      cfg_rdata = {16'h0000, lat_q, 8'h00};
    else if (cfg_addr == CFG_AW'(IDX_INTR))
      cfg_rdata = any_native ? {16'h0000, 8'h01, line_q} : 32'h0;
    else begin
      for (int i = 0; i < NUM_BASE; i++)
        if (cfg_addr == CFG_AW'(IDX_PCMD + i))
          cfg_rdata = native[i/2] ? (base_val[i] | IO_SPACE_FLAG) : 32'h0;
    end
  end
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode #(
  parameter logic [31:0] CMD_LEG = 32'h1F0,
  parameter logic [31:0] CTL_LEG = 32'h3F6
) (
  input  logic        native,
  input  logic [31:0] io_addr,
  input  logic [31:0] cmd_base,
  input  logic [31:0] ctl_base,
  output logic        cmd_hit,
  output logic        ctl_hit
);
  logic [31:0] cmd_ref;
  assign cmd_ref = native ? cmd_base : CMD_LEG;
  assign cmd_hit = (io_addr[31:3] == cmd_ref[31:3]);
  assign ctl_hit = native ? ((io_addr[31:2] == ctl_base[31:2]) && (io_addr[1:0] == 2'b10))
                          : (io_addr == CTL_LEG);
endmodule

// File: rtl/ide_hit_arbiter.sv
module ide_hit_arbiter #(
  parameter int N = 4
) (
  input  logic         strobe,
  input  logic [N-1:0] raw,
  output logic [N-1:0] grant
);
  // lowest index wins
  assign grant = strobe ? (raw & (~raw + N'(1))) : '0;
endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] native,
  output logic [N-1:0] legacy_irq,
  output logic [N-1:0] native_irq
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    assign legacy_irq[c] = req[c] & ~native[c];
    assign native_irq[c] = req[c] &  native[c];
  end
endmodule

// File: rtl/ide_mode_decoder.sv
module ide_mode_decoder
  import ide_dec_pkg::*;
#(
  parameter int          CFG_AW   = 6,
  parameter logic [7:0]  REVISION = 8'h01,
  parameter logic [31:0] PRI_CMD_LEG = 32'h1F0,
  parameter logic [31:0] PRI_CTL_LEG = 32'h3F6,
  parameter logic [31:0] SEC_CMD_LEG = 32'h170,
  parameter logic [31:0] SEC_CTL_LEG = 32'h376
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              io_strobe,
  input  logic [31:0]       io_addr,
  output logic              pri_cmd_hit,
  output logic              pri_ctl_hit,
  output logic              sec_cmd_hit,
  output logic              sec_ctl_hit,
  input  logic              pri_irq_req,
  input  logic              sec_irq_req,
  output logic              pri_legacy_irq,
  output logic              sec_legacy_irq,
  output logic              pri_native_irq,
  output logic              sec_native_irq
);
  localparam int NCH = 2;
  localparam logic [NCH-1:0][31:0] CMD_LEG = {SEC_CMD_LEG, PRI_CMD_LEG};
  localparam logic [NCH-1:0][31:0] CTL_LEG = {SEC_CTL_LEG, PRI_CTL_LEG};

  logic [NCH-1:0]            native;
  logic [NUM_BASE-1:0][31:0] base_val;
  logic [2*NCH-1:0]          raw_hit;
  logic [2*NCH-1:0]          grant;
  logic [NCH-1:0]            leg_irq, nat_irq;
  logic                      pri_native, sec_native;

  assign pri_native = native[0];
  assign sec_native = native[1];

  ide_cfg_regs #(
    .CFG_AW(CFG_AW), .REVISION(REVISION),
    .PRI_CMD_LEG(PRI_CMD_LEG), .PRI_CTL_LEG(PRI_CTL_LEG),
    .SEC_CMD_LEG(SEC_CMD_LEG), .SEC_CTL_LEG(SEC_CTL_LEG)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .native(native), .base_val(base_val)
  );

  // raw_hit order = priority: {sec_ctl, sec_cmd, pri_ctl, pri_cmd}
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    ide_chan_decode #(.CMD_LEG(CMD_LEG[c]), .CTL_LEG(CTL_LEG[c])) u_dec (
      .native(native[c]), .io_addr(io_addr),
      .cmd_base(base_val[2*c]), .ctl_base(base_val[2*c+1]),
      .cmd_hit(raw_hit[2*c]), .ctl_hit(raw_hit[2*c+1])
    );
  end

  ide_hit_arbiter #(.N(2*NCH)) u_arb (.strobe(io_strobe), .raw(raw_hit), .grant(grant));

  assign {sec_ctl_hit, sec_cmd_hit, pri_ctl_hit, pri_cmd_hit} = grant;

  ide_irq_route #(.N(NCH)) u_irq (
    .req({sec_irq_req, pri_irq_req}), .native(native),
    .legacy_irq(leg_irq), .native_irq(nat_irq)
  );
  assign {sec_legacy_irq, pri_legacy_irq} = leg_irq;
  assign {sec_native_irq, pri_native_irq} = nat_irq;
endmodule

// File: rtl/ide_mode_decoder_chk.sv
module ide_mode_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        io_strobe,
  input logic        pri_cmd_hit,
  input logic        pri_ctl_hit,
  input logic        sec_cmd_hit,
  input logic        sec_ctl_hit,
  input logic        pri_irq_req,
  input logic        sec_irq_req,
  input logic        pri_legacy_irq,
  input logic        sec_legacy_irq,
  input logic        pri_native_irq,
  input logic        sec_native_irq,
  input logic        pri_native,
  input logic        sec_native
);
  logic [3:0] hits;
  assign hits = {sec_ctl_hit, sec_cmd_hit, pri_ctl_hit, pri_cmd_hit};

  p_id_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 6'h02) |-> (cfg_rdata[31:16] == 16'h0101 && cfg_rdata[15:12] == 4'h8
                              && cfg_rdata[11] && cfg_rdata[9]));

  p_hit_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hits));

  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_strobe |-> (hits == 4'b0000));

  p_pri_base_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_native && (cfg_addr == 6'h04 || cfg_addr == 6'h05)) |-> (cfg_rdata == 32'h0));

  p_sec_base_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_native && (cfg_addr == 6'h06 || cfg_addr == 6'h07)) |-> (cfg_rdata == 32'h0));

  p_intr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_native && !sec_native && cfg_addr == 6'h0F) |-> (cfg_rdata == 32'h0));

  p_pri_irq_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_legacy_irq && pri_native_irq) && ((pri_legacy_irq || pri_native_irq) == pri_irq_req));

  p_sec_irq_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_legacy_irq && sec_native_irq) && ((sec_legacy_irq || sec_native_irq) == sec_irq_req));

  p_misc_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 6'h03) |-> (cfg_rdata[31:16] == 16'h0 && cfg_rdata[7:0] == 8'h0));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr > 6'h07 && cfg_addr != 6'h0F) |-> (cfg_rdata == 32'h0));
endmodule

bind ide_mode_decoder ide_mode_decoder_chk u_chk (.*);

// File: tb/ide_mode_decoder_bench.sv
`timescale 1ns/1ps
module ide_mode_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_strobe = 1'b0;
  logic [31:0] io_addr = '0;
  logic        pri_cmd_hit, pri_ctl_hit, sec_cmd_hit, sec_ctl_hit;
  logic        pri_irq_req = 1'b0, sec_irq_req = 1'b0;
  logic        pri_legacy_irq, sec_legacy_irq, pri_native_irq, sec_native_irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ide_mode_decoder u_ide_mode_decoder (.*);

  // model state
  logic        m_pn, m_sn;
  logic [7:0]  m_lat, m_line;
  logic [31:0] m_base [4];

  function automatic logic [31:0] wmask(int i);
    return (i % 2 == 1) ? 32'hFFFF_FFFC : 32'hFFFF_FFF8;
  endfunction

  function automatic logic m_nat(int ch);
    return (ch == 0) ? m_pn : m_sn;
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] idx);
    case (idx)
      6'h02: return {16'h0101, 8'h8A | {5'b0, m_sn, 1'b0, m_pn}, 8'h01};
      6'h03: return {16'h0, m_lat, 8'h0};
      6'h04, 6'h05, 6'h06, 6'h07:
        return m_nat((int'(idx) - 4) / 2) ? ((m_base[int'(idx) - 4] & wmask(int'(idx) - 4)) | 32'h1) : 32'h0;
      6'h0F: return (m_pn || m_sn) ? {16'h0, 8'h01, m_line} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] exp_hits(logic [31:0] a, logic s);
    logic [3:0] r;
    if (!s) return 4'b0;
    r[0] = m_pn ? (a[31:3] == m_base[0][31:3]) : (a[31:3] == 29'h3E);
    r[1] = m_pn ? (a[31:2] == m_base[1][31:2] && a[1:0] == 2'b10) : (a == 32'h3F6);
    r[2] = m_sn ? (a[31:3] == m_base[2][31:3]) : (a[31:3] == 29'h2E);
    r[3] = m_sn ? (a[31:2] == m_base[3][31:2] && a[1:0] == 2'b10) : (a == 32'h376);
    if (r[0]) return 4'b0001;
    if (r[1]) return 4'b0010;
    if (r[2]) return 4'b0100;
    if (r[3]) return 4'b1000;
    return 4'b0;
  endfunction

  task automatic model_reset();
    m_pn = 0; m_sn = 0; m_lat = 0; m_line = 0;
    m_base[0] = 32'h1F0; m_base[1] = 32'h3F4; m_base[2] = 32'h170; m_base[3] = 32'h374;
  endtask

  task automatic cfg_write(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
    logic pn, sn;
    @(negedge clk);
    cfg_wr = 1; cfg_addr = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    pn = m_pn; sn = m_sn;
    if (idx == 6'h02 && be[1]) begin m_pn = d[8]; m_sn = d[10]; end
    if (idx == 6'h03 && be[1]) m_lat = d[15:8];
    if (idx == 6'h0F && be[0] && (pn || sn)) m_line = d[7:0];
    if (idx >= 6'h04 && idx <= 6'h07) begin
      int i = int'(idx) - 4;
      if (((i / 2) == 0) ? pn : sn)
        for (int b = 0; b < 4; b++)
          if (be[b]) m_base[i][b*8 +: 8] = d[b*8 +: 8];
    end
  endtask

  task automatic chk_read(logic [5:0] idx, string tag);
    logic [31:0] e;
    cfg_addr = idx;
    #1;
    e = exp_read(idx);
    checks++;
    if (cfg_rdata !== e) begin
      failures++;
      $display("FAIL %s idx=%0h actual=%08h expected=%08h", tag, idx, cfg_rdata, e);
    end
  endtask

  task automatic chk_io(logic [31:0] a, logic s, string tag);
    logic [3:0] e;
    io_addr = a; io_strobe = s;
    #1;
    e = exp_hits(a, s);
    checks++;
    if ({sec_ctl_hit, sec_cmd_hit, pri_ctl_hit, pri_cmd_hit} !== e) begin
      failures++;
      $display("FAIL %s addr=%08h actual=%b expected=%b", tag, a,
               {sec_ctl_hit, sec_cmd_hit, pri_ctl_hit, pri_cmd_hit}, e);
    end
  endtask

  task automatic chk_irq(logic p, logic s);
    logic [3:0] e;
    pri_irq_req = p; sec_irq_req = s;
    #1;
    e = {s & m_sn, p & m_pn, s & ~m_sn, p & ~m_pn};
    checks++;
    if ({sec_native_irq, pri_native_irq, sec_legacy_irq, pri_legacy_irq} !== e) begin
      failures++;
      $display("FAIL R8 irq actual=%b expected=%b",
               {sec_native_irq, pri_native_irq, sec_legacy_irq, pri_legacy_irq}, e);
    end
  endtask

  task automatic read_all(string tag);
    chk_read(6'h02, {tag, " R1 R2"});
    chk_read(6'h03, {tag, " R9"});
    for (int i = 4; i < 8; i++) chk_read(6'(i), {tag, " R5 R6"});
    chk_read(6'h0F, {tag, " R7"});
    chk_read(6'h00, {tag, " R12"});
    chk_read(6'h11, {tag, " R12"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state R1 R6 R7
    read_all("reset");
    // compatibility decode R3, strobe gating R11
    chk_io(32'h1F0, 1, "R3"); chk_io(32'h1F7, 1, "R3"); chk_io(32'h1F8, 1, "R3");
    chk_io(32'h3F6, 1, "R3"); chk_io(32'h3F7, 1, "R3"); chk_io(32'h170, 1, "R3");
    chk_io(32'h376, 1, "R3"); chk_io(32'h1F0, 0, "R11");
    // compat ignores base and line writes R5 R7
    cfg_write(6'h04, 4'hF, 32'h0000_1000);
    cfg_write(6'h0F, 4'hF, 32'hFFFF_FFFF);
    cfg_write(6'h02, 4'hD, 32'hFFFF_FFFF); // R2: byte 1 disabled, no change
    read_all("compat");
    // enter native on both: R6 visible reset bases
    cfg_write(6'h02, 4'h2, 32'h0000_0500);
    read_all("native");
    chk_io(32'h1F0, 1, "R4"); chk_io(32'h3F6, 1, "R4"); chk_io(32'h3F4, 1, "R4");
    // program bases R4, R10
    cfg_write(6'h04, 4'h3, 32'hABCD_1007);
    cfg_write(6'h05, 4'hF, 32'h0000_2003);
    cfg_write(6'h0F, 4'h1, 32'h0000_AA5C);
    read_all("prog");
    chk_io(32'h1000, 1, "R4"); chk_io(32'h1007, 1, "R4"); chk_io(32'h1F0, 1, "R4");
    chk_io(32'h2002, 1, "R4"); chk_io(32'h2000, 1, "R4"); chk_io(32'h2003, 1, "R4");
    // overlap priority R11
    cfg_write(6'h06, 4'hF, 32'h0000_1000);
    cfg_write(6'h07, 4'hF, 32'h0000_1000);
    chk_io(32'h1002, 1, "R11 overlap");
    cfg_write(6'h04, 4'hF, 32'h0000_8000);
    chk_io(32'h1002, 1, "R11 overlap");
    chk_io(32'h2002, 1, "R11");
    chk_irq(1, 1); chk_irq(1, 0);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int k = $urandom % 10;
      if (k < 3) begin
        logic [5:0] ids [9] = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0F, 6'h00, 6'h10};
        logic [31:0] d = $urandom;
        int w = $urandom % 9;
        if (w >= 2 && w <= 5 && ($urandom % 2 == 1)) d = {20'h0, 4'($urandom), 8'($urandom)};
        cfg_write(ids[w], 4'($urandom), d);
        @(negedge clk);
        read_all("rand R10");
      end else if (k < 8) begin
        logic [31:0] a;
        int s = $urandom % 6;
        @(negedge clk);
        if (s < 4) a = ((m_nat(s / 2)) ? m_base[s] : ((s == 0) ? 32'h1F0 : (s == 1) ? 32'h3F0 :
                        (s == 2) ? 32'h170 : 32'h370)) + 32'($urandom % 8);
        else if (s == 4) a = 32'h0100 + 32'($urandom % 1024);
        else a = $urandom;
        chk_io(a, ($urandom % 8) != 0, "rand R3 R4 R11");
      end else begin
        @(negedge clk);
        chk_irq(1'($urandom), 1'($urandom));
      end
    end
    // back to compat, stored line hidden R7
    cfg_write(6'h02, 4'h2, 32'h0);
    read_all("final");
    chk_irq(1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule